// File: doc/BRIEF.md
# Control Endpoint Shared Byte Buffer

This block is the data buffer behind a USB device's control endpoint. One small store of bytes is shared by the USB engine and the local microcontroller, and it carries traffic one way at a time. After reset it carries bytes from the host to the microcontroller. The USB engine pushes a packet in and raises a receive-ready flag. The microcontroller reads the bytes through one byte-wide register port, where each read takes the oldest byte, and then clears the flag.

When the packet was a setup packet, clearing the flag on an empty buffer turns the buffer around. From then on the microcontroller writes bytes through the same port, each write appending one byte, and sets a transmit-ready flag. The USB engine then pops the bytes out toward the host. A fresh setup strobe from the USB side always returns the buffer to the receive direction and discards whatever was still queued.

Top module: `ctl_ep_fifo`

## Requirements
- R1: After reset the direction output `dir_m2h` is 0 (host-to-MCU), `level` is 0, and `rx_rdy`, `tx_rdy` and `overflow` are all 0.
- R2: While `dir_m2h` is 0, each `usb_push` stores `usb_wdata`. `mcu_rdata` shows the oldest stored byte combinationally, and each `mcu_rd` removes that byte, so bytes leave in arrival order.
- R3: While `dir_m2h` is 1, each `mcu_wr` stores `mcu_wdata`. `usb_rdata` shows the oldest stored byte, and each `usb_pop` removes it in arrival order.
- R4: A push or pop from the side that does not own the current direction leaves `level` unchanged. The inactive side's read-data output is 0x00.
- R5: `level` never exceeds DEPTH (8). A push into a full buffer is dropped and sets `overflow`, which then stays 1 until reset.
- R6: With the buffer empty, the active reader's data output is 0x00, and a pop leaves `level` at 0.
- R7: A `usb_setup` strobe overrides every other input in its cycle. On the next cycle `dir_m2h` is 0, `level` is 0, `rx_rdy` and `tx_rdy` are 0, and a setup is pending.
- R8: `mcu_rx_clr` while a setup is pending and the buffer is empty sets `dir_m2h` to 1 on the next cycle, with `level` 0 and pointers restarted. Without a pending setup, or with bytes still stored, the direction stays put.
- R9: `usb_rx_set` sets `rx_rdy` only while `dir_m2h` is 0. `mcu_rx_clr` clears it, and the clear wins if both arrive in the same cycle.
- R10: `mcu_tx_set` sets `tx_rdy` only while `dir_m2h` is 1. `usb_tx_done` or a setup strobe clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcu_wr | input | 1 | MCU register write, pushes one byte |
| mcu_wdata | input | 8 | MCU write byte |
| mcu_rd | input | 1 | MCU register read, pops one byte |
| mcu_rdata | output | 8 | Oldest byte as seen by the MCU |
| mcu_rx_clr | input | 1 | MCU releases the receive-ready flag |
| mcu_tx_set | input | 1 | MCU hands a packet to the USB side |
| usb_push | input | 1 | USB side stores one byte |
| usb_wdata | input | 8 | USB side byte in |
| usb_pop | input | 1 | USB side removes one byte |
| usb_rdata | output | 8 | Oldest byte as seen by the USB side |
| usb_setup | input | 1 | Setup packet strobe |
| usb_rx_set | input | 1 | Packet landed, raise receive-ready |
| usb_tx_done | input | 1 | Packet sent, drop transmit-ready |
| dir_m2h | output | 1 | 0 host-to-MCU, 1 MCU-to-host |
| rx_rdy | output | 1 | Receive-ready flag |
| tx_rdy | output | 1 | Transmit-ready flag |
| level | output | 4 | Bytes stored |
| overflow | output | 1 | Sticky push-into-full flag |

## Verification
A wrong pointer shows up on the very next pop as a byte out of order, or as a stale byte where 0x00 was due. A wrong count shows up at once on `level`, and after at most DEPTH pushes as a missing or premature overflow. Direction state that has gone wrong shows up one cycle after the strobe or release that should have moved it: `dir_m2h` stays put, pushes from the wrong side get accepted, or the inactive read port shows a nonzero byte.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  typedef enum logic {
    DIR_H2M = 1'b0,
    DIR_M2H = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/cef_buf.sv
module cef_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] fill,
  output logic          empty,
  output logic          ovf_hit
);
  logic [PW-1:0] wp, wp_d, rp, rp_d;
  logic [CW-1:0] cnt_d;
  logic          full, push_ok, pop_ok;
  logic [DEPTH-1:0] slot_we;
  logic [DW-1:0] mem [DEPTH];

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign push_ok = push_req && !full && !flush;
  assign pop_ok  = pop_req && !empty && !flush;
  assign ovf_hit = push_req && full && !flush;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wp_d  = wp;
    rp_d  = rp;
    cnt_d = fill;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_ok) wp_d = bump(wp);
      if (pop_ok)  rp_d = bump(rp);
      if (push_ok && !pop_ok)      cnt_d = fill + 1'b1;
      else if (pop_ok && !push_ok) cnt_d = fill - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      wp   <= wp_d;
      rp   <= rp_d;
      fill <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign slot_we[g] = push_ok && (wp == PW'(g));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_we[i]) mem[i] <= push_data;
    end
  end

  assign head_data = empty ? '0 : mem[rp];
endmodule

// File: rtl/cef_ctrl.sv
module cef_ctrl
  import ctl_ep_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      setup,
  input  logic      rx_set,
  input  logic      rx_clr,
  input  logic      tx_set,
  input  logic      tx_done,
  input  logic      buf_empty,
  input  logic      ovf_hit,
  output xfer_dir_e dir,
  output logic      rx_rdy,
  output logic      tx_rdy,
  output logic      overflow,
  output logic      flush
);
  xfer_dir_e dir_d;
  logic rx_d, tx_d, pend, pend_d, ovf_d, flip;

  assign flip  = !setup && rx_clr && pend && buf_empty && (dir == DIR_H2M);
  assign flush = setup || flip;

  always_comb begin
    dir_d  = dir;
    rx_d   = rx_rdy;
    tx_d   = tx_rdy;
    pend_d = pend;
    ovf_d  = overflow || ovf_hit;
    if (setup) begin
      dir_d  = DIR_H2M;
      rx_d   = 1'b0;
      tx_d   = 1'b0;
      pend_d = 1'b1;
    end else begin
      if (rx_clr)                       rx_d = 1'b0;
      else if (rx_set && dir == DIR_H2M) rx_d = 1'b1;
      if (tx_done)                      tx_d = 1'b0;
      else if (tx_set && dir == DIR_M2H) tx_d = 1'b1;
      if (flip) begin
        dir_d  = DIR_M2H;
        pend_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir      <= DIR_H2M;
      rx_rdy   <= 1'b0;
      tx_rdy   <= 1'b0;
      pend     <= 1'b0;
      overflow <= 1'b0;
    end else begin
      dir      <= dir_d;
      rx_rdy   <= rx_d;
      tx_rdy   <= tx_d;
      pend     <= pend_d;
      overflow <= ovf_d;
    end
  end
endmodule

// File: rtl/ctl_ep_fifo.sv
module ctl_ep_fifo
  import ctl_ep_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mcu_wr,
  input  logic [DW-1:0] mcu_wdata,
  input  logic          mcu_rd,
  output logic [DW-1:0] mcu_rdata,
  input  logic          mcu_rx_clr,
  input  logic          mcu_tx_set,
  input  logic          usb_push,
  input  logic [DW-1:0] usb_wdata,
  input  logic          usb_pop,
  output logic [DW-1:0] usb_rdata,
  input  logic          usb_setup,
  input  logic          usb_rx_set,
  input  logic          usb_tx_done,
  output logic          dir_m2h,
  output logic          rx_rdy,
  output logic          tx_rdy,
  output logic [CW-1:0] level,
  output logic          overflow
);
  xfer_dir_e     dir;
  logic          flush, buf_empty, ovf_hit, push_req, pop_req;
  logic [DW-1:0] push_data, head;

  assign push_req  = (dir == DIR_H2M) ? usb_push  : mcu_wr;
  assign push_data = (dir == DIR_H2M) ? usb_wdata : mcu_wdata;
  assign pop_req   = (dir == DIR_H2M) ? mcu_rd    : usb_pop;

  cef_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
    .head_data(head), .fill(level), .empty(buf_empty), .ovf_hit(ovf_hit)
  );

  cef_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .setup(usb_setup),
    .rx_set(usb_rx_set), .rx_clr(mcu_rx_clr),
    .tx_set(mcu_tx_set), .tx_done(usb_tx_done),
    .buf_empty(buf_empty), .ovf_hit(ovf_hit),
    .dir(dir), .rx_rdy(rx_rdy), .tx_rdy(tx_rdy),
    .overflow(overflow), .flush(flush)
  );

  assign dir_m2h   = (dir == DIR_M2H);
  assign mcu_rdata = (dir == DIR_H2M) ? head : '0;
  assign usb_rdata = (dir == DIR_M2H) ? head : '0;
endmodule

// File: rtl/cef_chk.sv
module cef_chk #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mcu_wr,
  input logic          usb_pop,
  input logic          usb_setup,
  input logic          mcu_rx_clr,
  input logic          usb_tx_done,
  input logic [DW-1:0] mcu_rdata,
  input logic [DW-1:0] usb_rdata,
  input logic          dir_m2h,
  input logic          tx_rdy,
  input logic [CW-1:0] level,
  input logic          overflow
);
  // R5
  level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  // R5
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R7
  setup_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_setup |=> (!dir_m2h && level == '0 && !tx_rdy));

  // R8
  flip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_m2h) |-> ($past(mcu_rx_clr) && $past(level) == '0 && level == '0));

  // R4
  idle_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_m2h ? (mcu_rdata == '0) : (usb_rdata == '0)));

  // R4
  m2h_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_m2h && !mcu_wr && !usb_pop && !usb_setup) |=> $stable(level));

  // R10
  tx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    usb_tx_done |=> !tx_rdy);
endmodule

bind ctl_ep_fifo cef_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mcu_wr(mcu_wr), .usb_pop(usb_pop),
  .usb_setup(usb_setup), .mcu_rx_clr(mcu_rx_clr), .usb_tx_done(usb_tx_done),
  .mcu_rdata(mcu_rdata), .usb_rdata(usb_rdata), .dir_m2h(dir_m2h),
  .tx_rdy(tx_rdy), .level(level), .overflow(overflow)
);

// File: tb/sim_ctl_ep_fifo.sv
module sim_ctl_ep_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int LIMIT = 50000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mcu_wr = 0, mcu_rd = 0, mcu_rx_clr = 0, mcu_tx_set = 0;
  logic usb_push = 0, usb_pop = 0, usb_setup = 0, usb_rx_set = 0, usb_tx_done = 0;
  logic [7:0] mcu_wdata = 0, usb_wdata = 0, mcu_rdata, usb_rdata;
  logic dir_m2h, rx_rdy, tx_rdy, overflow;
  logic [3:0] level;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_ep_fifo u0 (
    .clk(clk), .rst_n(rst_n), .mcu_wr(mcu_wr), .mcu_wdata(mcu_wdata),
    .mcu_rd(mcu_rd), .mcu_rdata(mcu_rdata), .mcu_rx_clr(mcu_rx_clr),
    .mcu_tx_set(mcu_tx_set), .usb_push(usb_push), .usb_wdata(usb_wdata),
    .usb_pop(usb_pop), .usb_rdata(usb_rdata), .usb_setup(usb_setup),
    .usb_rx_set(usb_rx_set), .usb_tx_done(usb_tx_done), .dir_m2h(dir_m2h),
    .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .level(level), .overflow(overflow)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    mcu_wr = 0; mcu_rd = 0; mcu_rx_clr = 0; mcu_tx_set = 0;
    usb_push = 0; usb_pop = 0; usb_setup = 0; usb_rx_set = 0; usb_tx_done = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    step(); step();
    rst_n = 1;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", LIMIT, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    check("R1 dir", dir_m2h, 0);
    check("R1 level", level, 0);
    check("R1 rx", rx_rdy, 0);
    check("R1 tx", tx_rdy, 0);
    check("R1 ovf", overflow, 0);

    // R8 release without pending setup keeps direction
    mcu_rx_clr = 1; step();
    check("R8 no-pending", dir_m2h, 0);

    for (int n = 0; n <= DEPTH + 2; n++) begin
      int kept;
      kept = (n > DEPTH) ? DEPTH : n;
      do_reset();
      usb_setup = 1; step();
      // R7
      check("R7 dir", dir_m2h, 0);
      check("R7 level", level, 0);
      for (int i = 0; i < n; i++) begin
        usb_push = 1; usb_wdata = 8'((n * 16 + i) ^ 8'h5A); step();
      end
      // R5 saturation and sticky overflow
      check("R5 level", level, kept);
      check("R5 ovf", overflow, (n > DEPTH) ? 1 : 0);
      // R4 MCU write in host-to-MCU direction ignored
      mcu_wr = 1; mcu_wdata = 8'hEE; step();
      check("R4 h2m wr", level, kept);
      check("R4 usb_rdata idle", usb_rdata, 0);
      usb_rx_set = 1; step();
      check("R9 set", rx_rdy, 1);
      // R2 arrival order
      for (int i = 0; i < kept; i++) begin
        check("R2 data", mcu_rdata, (n * 16 + i) ^ 8'h5A);
        mcu_rd = 1; step();
      end
      // R6 empty pop
      check("R6 rdata", mcu_rdata, 0);
      mcu_rd = 1; step();
      check("R6 level", level, 0);
      // R8 release with pending setup flips; R9 clear wins
      mcu_rx_clr = 1; usb_rx_set = 1; step();
      check("R9 clr", rx_rdy, 0);
      check("R8 flip", dir_m2h, 1);
      check("R8 level", level, 0);
      check("R5 ovf sticky", overflow, (n > DEPTH) ? 1 : 0);
      // R9 rx_set ignored in MCU-to-host
      usb_rx_set = 1; step();
      check("R9 m2h ignore", rx_rdy, 0);
      // R4 USB push ignored in MCU-to-host
      usb_push = 1; usb_wdata = 8'h33; step();
      check("R4 m2h push", level, 0);
      for (int i = 0; i < n; i++) begin
        mcu_wr = 1; mcu_wdata = 8'(n * 8 + i + 8'h80); step();
      end
      check("R3 level", level, kept);
      mcu_tx_set = 1; step();
      check("R10 set", tx_rdy, 1);
      for (int i = 0; i < kept; i++) begin
        check("R3 data", usb_rdata, (n * 8 + i + 8'h80) & 8'hFF);
        check("R4 mcu_rdata idle", mcu_rdata, 0);
        usb_pop = 1; step();
      end
      check("R6 usb empty", usb_rdata, 0);
      usb_tx_done = 1; step();
      check("R10 done", tx_rdy, 0);
    end

    // R8 release with bytes still stored does not flip
    do_reset();
    usb_setup = 1; step();
    usb_push = 1; usb_wdata = 8'h11; step();
    usb_push = 1; usb_wdata = 8'h22; step();
    mcu_rx_clr = 1; step();
    check("R8 nonempty", dir_m2h, 0);
    check("R8 kept", level, 2);
    // R10 tx_set ignored in host-to-MCU
    mcu_tx_set = 1; step();
    check("R10 h2m ignore", tx_rdy, 0);
    // R7 setup overrides simultaneous push
    usb_setup = 1; usb_push = 1; usb_wdata = 8'h44; step();
    check("R7 flush", level, 0);
    // R7 setup in MCU-to-host flushes and clears tx
    mcu_rx_clr = 1; step();
    check("R8 flip2", dir_m2h, 1);
    mcu_wr = 1; mcu_wdata = 8'h55; step();
    mcu_tx_set = 1; step();
    usb_setup = 1; mcu_wr = 1; step();
    check("R7 back", dir_m2h, 0);
    check("R7 level2", level, 0);
    check("R7 tx", tx_rdy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule